// File: doc/BRIEF.md
# Token-Passing Transmit Handshake Sequencer

This block runs one node's transmit cycle on a token-passing network. The host places the packet body in an external byte buffer, then presents a destination ID and a payload length together with a one-cycle transmit-enable pulse. The sequencer latches these values and clears its transmitter-available flag. It then waits until the node holds the token. It first asks the destination whether it has a free buffer, by sending a one-byte enquiry frame. If the destination agrees, it streams the data frame with a CRC-16 trailer and listens for a delivery acknowledgement. A refusal ends the cycle at once, and so does a missing reply. At the end of every cycle the token is passed on and the available flag sets again.

The states are IDLE (waiting for a command), ARMED (command latched, waiting for the token), ENQ (enquiry byte on the serializer port), ENQ_WAIT (reply-wait timer running), DATA (one data-frame byte per cycle), ACK_WAIT (timer running for the delivery reply) and PASS (token handed on for one cycle). The transitions are:

- IDLE→ARMED on an accepted enable.
- ARMED→ENQ on token.
- ENQ→ENQ_WAIT always.
- ENQ_WAIT→DATA on ACK.
- ENQ_WAIT→PASS on NAK or timer expiry.
- DATA→ACK_WAIT after the last byte.
- ACK_WAIT→PASS on ACK or expiry.
- PASS→IDLE always.

Top module: `txseq_top`

## Requirements
- R1: After reset sts_avail=1, sts_dlvd=0, irq=0, ser_vld=0 and token_pass=0, and the mask register is 0.
- R2: A txen pulse in IDLE latches dest_id and pkt_len and clears sts_avail and sts_dlvd on that edge. No frame is sent while token_held stays low.
- R3: The cycle after token_held is sampled high in ARMED, exactly one frame byte is presented: ser_vld=1, ser_kind=2'b01 (enquiry), ser_byte=latched destination ID, ser_last=1.
- R4: When rx_ack is sampled during ENQ_WAIT, a data frame follows on the next cycle with ser_kind=2'b10 and one byte per cycle. The byte order is destination ID, length, payload bytes read from buf_addr 0 to length-1, CRC high byte, CRC low byte. ser_last is set only on the final byte. A length of 0 is allowed.
- R5: The CRC is CRC-16 with polynomial 0x8005 and initial value 0x0000, processed MSB first with no reflection and no final XOR. It is computed over the destination ID, the length and the payload bytes.
- R6: rx_nak sampled during ENQ_WAIT sends no data. token_pass pulses the next cycle, then sts_avail=1 and sts_dlvd=0.
- R7: With no reply, ENQ_WAIT lasts WAIT_CYC cycles. token_pass then pulses WAIT_CYC+1 cycles after the enquiry cycle, and no data is sent.
- R8: rx_ack sampled during ACK_WAIT sets sts_dlvd and passes the token. sts_avail is 1 after the PASS cycle.
- R9: With no reply after the data frame, token_pass pulses WAIT_CYC+1 cycles after the last data byte. sts_dlvd stays 0 and sts_avail returns to 1.
- R10: irq is high exactly when (mask bit 0 and sts_avail) or (mask bit 1 and sts_dlvd). The mask is written with msk_we and msk_wdata.
- R11: txen in any state other than IDLE is ignored. The latched destination, length and cycle progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txen | input | 1 | Transmit-enable command pulse |
| dest_id | input | 8 | Destination node ID, latched on accepted txen |
| pkt_len | input | 8 | Payload byte count, latched on accepted txen |
| token_held | input | 1 | Node currently holds the token |
| token_pass | output | 1 | One-cycle request to pass the token on |
| buf_addr | output | 8 | Payload buffer read address |
| buf_data | input | 8 | Payload byte at buf_addr (asynchronous read) |
| ser_vld | output | 1 | Frame byte valid toward the serializer |
| ser_kind | output | 2 | Frame type: 01 enquiry, 10 data |
| ser_byte | output | 8 | Frame byte |
| ser_last | output | 1 | Final byte of the frame |
| rx_ack | input | 1 | ACK reply received |
| rx_nak | input | 1 | NAK reply received |
| msk_we | input | 1 | Interrupt mask write strobe |
| msk_wdata | input | 2 | Mask value: bit0 available, bit1 delivered |
| sts_avail | output | 1 | Transmitter available status |
| sts_dlvd | output | 1 | Delivery acknowledged status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the two timeout exits. In these, nothing happens at the ports while the reply-wait timer runs to exactly its limit. The bench withholds rx_ack and rx_nak, once after the enquiry and once after a data frame. It counts the cycles from the enquiry or last byte up to the token_pass pulse. A second enable is also issued while the block is ARMED. The enquiry byte that follows then shows that the latched destination was not overwritten.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
    localparam int BYTE_W = 8;
    localparam int NSTS   = 2;
    localparam logic [15:0] CRC_POLY = 16'h8005;
    localparam logic [15:0] CRC_INIT = 16'h0000;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ARMED, ST_ENQ, ST_ENQ_WAIT, ST_DATA, ST_ACK_WAIT, ST_PASS
    } seq_state_t;

    typedef enum logic [1:0] {
        FK_NONE = 2'b00,
        FK_ENQ  = 2'b01,
        FK_DATA = 2'b10
    } frame_kind_t;
endpackage

// File: rtl/txseq_crc16.sv
module txseq_crc16
    import txseq_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [15:0]       crc
);
    logic [15:0] crc_q, crc_nxt;
    logic        fb;

    always_comb begin
        crc_nxt = crc_q;
        fb      = 1'b0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb      = crc_nxt[15] ^ din[i];
            crc_nxt = {crc_nxt[14:0], 1'b0};
            if (fb) crc_nxt = crc_nxt ^ CRC_POLY;
        end
    end

    always_ff @(posedge clk) begin
        if (clr)     crc_q <= CRC_INIT;
        else if (en) crc_q <= crc_nxt;
    end

    assign crc = crc_q;
endmodule

// File: rtl/txseq_timer.sv
module txseq_timer #(
    parameter int WAIT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(WAIT_CYC - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/txseq_status.sv
module txseq_status
    import txseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            cyc_end,
    input  logic            dlv_ok,
    input  logic            msk_we,
    input  logic [NSTS-1:0] msk_wdata,
    output logic            sts_avail,
    output logic            sts_dlvd,
    output logic [NSTS-1:0] msk_q,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_avail <= 1'b1;
            sts_dlvd  <= 1'b0;
            msk_q     <= '0;
        end else begin
            if (arm) begin
                sts_avail <= 1'b0;
                sts_dlvd  <= 1'b0;
            end else begin
                if (cyc_end) sts_avail <= 1'b1;
                if (dlv_ok)  sts_dlvd  <= 1'b1;
            end
            if (msk_we) msk_q <= msk_wdata;
        end
    end

    assign irq = |({sts_dlvd, sts_avail} & msk_q);
endmodule

// File: rtl/txseq_top.sv
module txseq_top
    import txseq_pkg::*;
#(
    parameter int WAIT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txen,
    input  logic [BYTE_W-1:0] dest_id,
    input  logic [BYTE_W-1:0] pkt_len,
    input  logic              token_held,
    output logic              token_pass,
    output logic [BYTE_W-1:0] buf_addr,
    input  logic [BYTE_W-1:0] buf_data,
    output logic              ser_vld,
    output logic [1:0]        ser_kind,
    output logic [BYTE_W-1:0] ser_byte,
    output logic              ser_last,
    input  logic              rx_ack,
    input  logic              rx_nak,
    input  logic              msk_we,
    input  logic [NSTS-1:0]   msk_wdata,
    output logic              sts_avail,
    output logic              sts_dlvd,
    output logic              irq
);
    localparam int IDX_W = BYTE_W + 1;

    seq_state_t        st_q, st_d;
    logic [BYTE_W-1:0] dest_q, len_q;
    logic [IDX_W-1:0]  idx_q, last_idx;
    logic              arm, cyc_end, dlv_ok;
    logic              tmr_run, tmr_exp;
    logic              crc_clr, crc_en;
    logic [15:0]       crc_val;
    logic [NSTS-1:0]   msk_q;

    assign arm      = txen && (st_q == ST_IDLE);
    assign last_idx = {1'b0, len_q} + IDX_W'(3);
    assign tmr_run  = (st_q == ST_ENQ_WAIT) || (st_q == ST_ACK_WAIT);
    assign cyc_end  = (st_q == ST_PASS);
    assign dlv_ok   = (st_q == ST_ACK_WAIT) && rx_ack;
    assign crc_clr  = (st_q != ST_DATA);
    assign crc_en   = (st_q == ST_DATA) && (idx_q < last_idx - IDX_W'(1));
    assign buf_addr = idx_q[BYTE_W-1:0] - BYTE_W'(2);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // command latch and byte index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
        end else begin
            if (arm) begin
                dest_q <= dest_id;
                len_q  <= pkt_len;
            end
            if (st_q == ST_DATA) idx_q <= idx_q + 1'b1;
            else                 idx_q <= '0;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (txen) st_d = ST_ARMED;
            ST_ARMED:    if (token_held) st_d = ST_ENQ;
            ST_ENQ:      st_d = ST_ENQ_WAIT;
            ST_ENQ_WAIT: begin
                if (rx_ack)                  st_d = ST_DATA;
                else if (rx_nak || tmr_exp)  st_d = ST_PASS;
            end
            ST_DATA:     if (idx_q == last_idx) st_d = ST_ACK_WAIT;
            ST_ACK_WAIT: if (rx_ack || tmr_exp) st_d = ST_PASS;
            ST_PASS:     st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ser_vld    = 1'b0;
        ser_kind   = FK_NONE;
        ser_byte   = '0;
        ser_last   = 1'b0;
        token_pass = 1'b0;
        unique case (st_q)
            ST_ENQ: begin
                ser_vld  = 1'b1;
                ser_kind = FK_ENQ;
                ser_byte = dest_q;
                ser_last = 1'b1;
            end
            ST_DATA: begin
                ser_vld  = 1'b1;
                ser_kind = FK_DATA;
                ser_last = (idx_q == last_idx);
                if (idx_q == IDX_W'(0))                  ser_byte = dest_q;
                else if (idx_q == IDX_W'(1))             ser_byte = len_q;
                else if (idx_q == last_idx - IDX_W'(1))  ser_byte = crc_val[15:8];
                else if (idx_q == last_idx)              ser_byte = crc_val[7:0];
                else                                     ser_byte = buf_data;
            end
            ST_PASS:  token_pass = 1'b1;
            default: ;
        endcase
    end

    txseq_crc16 u_crc (
        .clk (clk),
        .clr (crc_clr),
        .en  (crc_en),
        .din (ser_byte),
        .crc (crc_val)
    );

    txseq_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    txseq_status u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .cyc_end   (cyc_end),
        .dlv_ok    (dlv_ok),
        .msk_we    (msk_we),
        .msk_wdata (msk_wdata),
        .sts_avail (sts_avail),
        .sts_dlvd  (sts_dlvd),
        .msk_q     (msk_q),
        .irq       (irq)
    );
endmodule

// File: rtl/txseq_chk.sv
module txseq_chk
    import txseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       token_held,
    input logic       token_pass,
    input logic       ser_vld,
    input logic [1:0] ser_kind,
    input logic       ser_last,
    input logic       rx_ack,
    input logic       sts_avail,
    input logic       sts_dlvd,
    input logic [1:0] msk,
    input logic       irq
);
    // R3: an enquiry is a single byte frame
    a_r3_enq_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_vld && ser_kind == FK_ENQ) |-> ser_last);

    // R3: an enquiry only follows a sampled token
    a_r3_enq_after_token: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_vld && ser_kind == FK_ENQ) |-> $past(token_held));

    // R2: while a frame is on the port the transmitter is busy
    a_r2_busy_when_sending: assert property (@(posedge clk) disable iff (!rst_n)
        ser_vld |-> !sts_avail);

    // R6: passing the token restores availability
    a_r6_avail_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
        token_pass |=> sts_avail);

    // R8: delivered flag only rises after an ACK
    a_r8_dlvd_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_dlvd) |-> $past(rx_ack));

    // R10: unmasked status raises the interrupt
    a_r10_irq_avail: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_avail && msk[0]) |-> irq);

    a_r10_irq_dlvd: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_dlvd && msk[1]) |-> irq);
endmodule

bind txseq_top txseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .token_held (token_held),
    .token_pass (token_pass),
    .ser_vld    (ser_vld),
    .ser_kind   (ser_kind),
    .ser_last   (ser_last),
    .rx_ack     (rx_ack),
    .sts_avail  (sts_avail),
    .sts_dlvd   (sts_dlvd),
    .msk        (msk_q),
    .irq        (irq)
);

// File: tb/tb_txseq_top.sv
`timescale 1ns/1ps
module tb_txseq_top;
    localparam int WC = 20;
    localparam int NV = 6;
    // {dest, len, enq reply (0 ack,1 nak,2 none), post reply (0 ack,2 none), mask, exp_sent, exp_dlvd}
    localparam logic [23:0] VEC [0:NV-1] = '{
        {8'h12, 8'd5,   2'd0, 2'd0, 2'b10, 1'b1, 1'b1},
        {8'hA7, 8'd0,   2'd0, 2'd0, 2'b01, 1'b1, 1'b1},
        {8'h3C, 8'd8,   2'd1, 2'd0, 2'b11, 1'b0, 1'b0},
        {8'h55, 8'd3,   2'd2, 2'd0, 2'b10, 1'b0, 1'b0},
        {8'hF0, 8'd12,  2'd0, 2'd2, 2'b11, 1'b1, 1'b0},
        {8'h01, 8'd255, 2'd0, 2'd0, 2'b00, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txen = 1'b0, token_held = 1'b0, rx_ack = 1'b0, rx_nak = 1'b0, msk_we = 1'b0;
    logic [7:0] dest_id = '0, pkt_len = '0;
    logic [1:0] msk_wdata = '0;
    logic token_pass, ser_vld, ser_last, sts_avail, sts_dlvd, irq;
    logic [1:0] ser_kind;
    logic [7:0] ser_byte, buf_addr, buf_data;

    int total = 0, bad = 0;
    logic [7:0] got [0:299];

    always #2 clk = ~clk;

    assign buf_data = (buf_addr * 8'd29) + 8'h31;

    txseq_top #(.WAIT_CYC(WC)) dut (
        .clk(clk), .rst_n(rst_n), .txen(txen), .dest_id(dest_id), .pkt_len(pkt_len),
        .token_held(token_held), .token_pass(token_pass), .buf_addr(buf_addr),
        .buf_data(buf_data), .ser_vld(ser_vld), .ser_kind(ser_kind), .ser_byte(ser_byte),
        .ser_last(ser_last), .rx_ack(rx_ack), .rx_nak(rx_nak), .msk_we(msk_we),
        .msk_wdata(msk_wdata), .sts_avail(sts_avail), .sts_dlvd(sts_dlvd), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int k = 7; k >= 0; k--) begin
            if (r[15] ^ b[k]) r = (r << 1) ^ 16'h8005;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic run_cycle(input logic [7:0] d, input logic [7:0] l, input logic [1:0] er,
                             input logic [1:0] pr, input logic [1:0] msk, input bit xs, input bit xd);
        int nb = 0, cyc = 0, last_cyc = -1, pass_cyc = -1, errs = 0;
        bit ack_next = 0;
        logic [15:0] c = 16'h0000;
        logic xirq;
        msk_we = 1'b1; msk_wdata = msk;
        @(negedge clk); msk_we = 1'b0;
        txen = 1'b1; dest_id = d; pkt_len = l;
        @(negedge clk); txen = 1'b0;
        chk(sts_avail == 1'b0, "R2 avail cleared on enable", sts_avail, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!ser_vld, "R2 silent before token", ser_vld, 0);
        end
        token_held = 1'b1;
        @(negedge clk); token_held = 1'b0;
        chk(ser_vld && ser_kind == 2'b01 && ser_byte == d && ser_last, "R3 enquiry frame",
            {ser_vld, ser_kind, ser_last, ser_byte}, {1'b1, 2'b01, 1'b1, d});
        if (er != 2'd2) begin
            @(negedge clk);
            rx_ack = (er == 2'd0); rx_nak = (er == 2'd1);
            @(negedge clk);
            rx_ack = 1'b0; rx_nak = 1'b0;
        end
        for (int it = 0; it < 400; it++) begin
            rx_ack = 1'b0;
            if (ack_next) begin rx_ack = 1'b1; ack_next = 0; end
            if (token_pass) begin pass_cyc = cyc; break; end
            if (ser_vld && ser_kind == 2'b10) begin
                got[nb] = ser_byte; nb++;
                if (ser_last) begin
                    last_cyc = cyc;
                    if (pr == 2'd0) ack_next = 1;
                end
            end
            @(negedge clk);
            cyc++;
        end
        rx_ack = 1'b0;
        chk(pass_cyc >= 0, "R6/R7/R8/R9 token passed", pass_cyc, 1);
        chk((nb > 0) == xs, "R4/R6/R7 data sent", nb, xs);
        if (er == 2'd2)
            chk(pass_cyc == WC + 1, "R7 enquiry timeout length", pass_cyc, WC + 1);
        if (xs) begin
            chk(nb == l + 4, "R4 frame length", nb, l + 4);
            if (got[0] != d) errs++;
            if (got[1] != l) errs++;
            for (int i = 0; i < l; i++)
                if (got[2 + i] != 8'((i * 29) + 8'h31)) errs++;
            chk(errs == 0, "R4 byte order", errs, 0);
            for (int i = 0; i < l + 2; i++) c = crc_step(c, got[i]);
            chk({got[l + 2], got[l + 3]} == c, "R5 crc", {got[l + 2], got[l + 3]}, c);
            if (pr == 2'd2)
                chk(pass_cyc - last_cyc == WC + 1, "R9 ack timeout length", pass_cyc - last_cyc, WC + 1);
        end
        @(negedge clk);
        xirq = msk[0] | (msk[1] & xd);
        chk(sts_avail == 1'b1, "R6/R8/R9 avail restored", sts_avail, 1);
        chk(sts_dlvd == xd, "R8/R9 delivered flag", sts_dlvd, xd);
        chk(irq == xirq, "R10 irq", irq, xirq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sts_avail && !sts_dlvd && !irq && !ser_vld && !token_pass, "R1 reset state",
            {sts_avail, sts_dlvd, irq, ser_vld, token_pass}, 5'b10000);

        for (int v = 0; v < NV; v++)
            run_cycle(VEC[v][23:16], VEC[v][15:8], VEC[v][7:6], VEC[v][5:4],
                      VEC[v][3:2], VEC[v][1], VEC[v][0]);

        // R11: second enable while armed is ignored
        txen = 1'b1; dest_id = 8'h66; pkt_len = 8'd2;
        @(negedge clk); txen = 1'b0;
        @(negedge clk);
        txen = 1'b1; dest_id = 8'h99; pkt_len = 8'd7;
        @(negedge clk); txen = 1'b0;
        chk(!ser_vld && !sts_avail, "R11 no start from ignored enable", {ser_vld, sts_avail}, 0);
        token_held = 1'b1;
        @(negedge clk); token_held = 1'b0;
        chk(ser_byte == 8'h66, "R11 destination kept", ser_byte, 8'h66);
        @(negedge clk); rx_ack = 1'b1;
        @(negedge clk); rx_ack = 1'b0;
        @(negedge clk);
        chk(ser_byte == 8'd2, "R11 length kept", ser_byte, 2);
        repeat (WC + 8) @(negedge clk);
        chk(sts_avail && !sts_dlvd, "R9 silent after R11 frame", {sts_avail, sts_dlvd}, 2'b10);

        // R10: mask cleared leaves irq low
        msk_we = 1'b1; msk_wdata = 2'b00;
        @(negedge clk); msk_we = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R10 masked off", irq, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule